// File: doc/BRIEF.md
# Accumulator Bit-Field Extract Unit

This unit works on a 64-bit accumulator split into a high and a low 32-bit half, steered by a 6-bit position pointer that lives in an external control register. Its main job is to pull a right-aligned field of 1 to 32 bits out of the accumulator. The field's top bit is the pointer, and its length is the size operand plus one. If the pointer is too low to hold that many bits, the unit raises a failure flag and returns zero. One variant of the extract also moves the pointer down past the bits it consumed, so that a run of extracts walks through a packed bit stream.

Two companion operations keep the stream filled. A move pushes the old low half into the high half and loads a new 32-bit word into the low half, and it raises the pointer by 32 while that still makes sense. A signed shift moves the whole accumulator left or right. The unit holds no architectural storage of its own. The accumulator halves and the pointer come in on ports. Each result is registered and shown on the outputs one clock after the operation, with a one-cycle write strobe telling the owner of that storage to commit the new accumulator or pointer value.

Top module: `acc_field_unit`

## Requirements
- R1: While reset is asserted, and right after it, every output is zero: accumulator halves, both write strobes, the pointer output, the field and the failure flag.
- R2: An extract (op code 2'b00) or extract-and-step (2'b01) is legal when pointer minus (size+1) is at least -1, that is, when pointer >= size. A legal one outputs accumulator bits pointer down to pointer-size, right-aligned in `field_o` with the upper bits zero, and clears `fail_o`. Size is 5 bits, so the field length runs from 1 to 32.
- R3: An illegal extract of either kind (pointer < size) sets `fail_o` and makes `field_o` zero.
- R4: A legal extract-and-step sets `pos_we_o` and outputs pointer-(size+1), truncated to 6 bits (pointer == size gives 63). An illegal extract-and-step, or any plain extract, leaves `pos_we_o` low and `pos_o` unchanged. Neither kind of extract asserts `acc_we_o`.
- R5: A move (op code 2'b10) sets `acc_we_o`, outputs the old low half on `acc_hi_o`, and outputs `operand_i` on `acc_lo_o`.
- R6: A move whose input pointer is 32 or less sets `pos_we_o` and outputs pointer+32, truncated to 6 bits (32 gives 0). A move with a pointer above 32 leaves `pos_we_o` low and `pos_o` unchanged.
- R7: A shift (op code 2'b11) reads `operand_i[5:0]` as a two's-complement amount and ignores the other operand bits. A positive amount shifts the 64-bit accumulator right, filling with zeros. A negative amount shifts it left by its magnitude (-32 shifts left by 32). Zero leaves it unchanged. The result appears with `acc_we_o` set.
- R8: Every operation result appears one clock after the cycle in which `op_valid_i` is high. In a cycle with `op_valid_i` low, both strobes drop and `field_o`, `fail_o`, `pos_o` and the accumulator outputs hold. Move and shift leave `field_o` and `fail_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_code_i | input | 2 | 00 extract, 01 extract-and-step, 10 move, 11 shift |
| size_i | input | 5 | Field length minus one |
| operand_i | input | 32 | Data word for a move; shift amount in bits 5:0 |
| acc_hi_i | input | 32 | Current accumulator high half |
| acc_lo_i | input | 32 | Current accumulator low half |
| pos_i | input | 6 | Current pointer value |
| acc_hi_o | output | 32 | New accumulator high half |
| acc_lo_o | output | 32 | New accumulator low half |
| acc_we_o | output | 1 | One-cycle strobe: commit the accumulator outputs |
| pos_o | output | 6 | New pointer value |
| pos_we_o | output | 1 | One-cycle strobe: commit the pointer output |
| field_o | output | 32 | Extracted field, right-aligned |
| fail_o | output | 1 | Last extract did not have enough bits |

## Verification
The properties assume that the op code, size, operand, accumulator halves and pointer are fully defined in every cycle where `op_valid_i` is high. They also assume that only the cycle after a valid operation, and never a cycle still in reset, is read as that operation's result. The stimulus drives every input from $urandom at each falling edge, so no X ever reaches the unit, and it leaves `op_valid_i` low during reset. Idle cycles get random data as well, which exercises the claim that inputs are ignored when no operation is valid.

// File: rtl/afu_pkg.sv
package afu_pkg;

    localparam int HALF_W  = 32;
    localparam int ACC_W   = 2 * HALF_W;
    localparam int POS_W   = 6;
    localparam int SIZE_W  = 5;
    localparam int FIELD_W = 1 << SIZE_W;
    localparam int SHAMT_W = 6;

    typedef enum logic [1:0] {
        OP_EXTRACT     = 2'b00,
        OP_EXTRACT_DEC = 2'b01,
        OP_MOVE        = 2'b10,
        OP_SHIFT       = 2'b11
    } op_e;

    typedef struct packed {
        logic [HALF_W-1:0]  hi;
        logic [HALF_W-1:0]  lo;
        logic               acc_we;
        logic [POS_W-1:0]   pos;
        logic               pos_we;
        logic [FIELD_W-1:0] field;
        logic               fail;
    } state_t;

endpackage

// File: rtl/afu_field_extract.sv
module afu_field_extract #(
    parameter int ACC_W   = 64,
    parameter int POS_W   = 6,
    parameter int SIZE_W  = 5,
    parameter int FIELD_W = 32
) (
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [POS_W-1:0]   pos_i,
    input  logic [SIZE_W-1:0]  size_i,
    output logic               legal_o,
    output logic [FIELD_W-1:0] field_o
);
    localparam int CMP_W = POS_W + 1;

    logic [CMP_W-1:0]   pos_x;
    logic [CMP_W-1:0]   size_x;
    logic [POS_W-1:0]   low_bit;
    logic [ACC_W-1:0]   shifted;
    logic [FIELD_W:0]   one_hot;
    logic [FIELD_W:0]   len_mask;

    always_comb begin
        pos_x    = {1'b0, pos_i};
        size_x   = CMP_W'(size_i);
        legal_o  = (pos_x >= size_x);
        low_bit  = pos_i - POS_W'(size_i);
        shifted  = acc_i >> low_bit;
        one_hot  = (FIELD_W + 1)'(1) << ({1'b0, size_i} + (SIZE_W + 1)'(1));
        len_mask = one_hot - (FIELD_W + 1)'(1);
        field_o  = legal_o ? (shifted[FIELD_W-1:0] & len_mask[FIELD_W-1:0])
                           : '0;
    end

endmodule

// File: rtl/afu_acc_shift.sv
module afu_acc_shift #(
    parameter int ACC_W   = 64,
    parameter int SHAMT_W = 6
) (
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [SHAMT_W-1:0] amount_i,
    output logic [ACC_W-1:0]   acc_o
);
    logic               go_left;
    logic [SHAMT_W-1:0] magnitude;

    always_comb begin
        go_left   = amount_i[SHAMT_W-1];
        magnitude = go_left ? (~amount_i + SHAMT_W'(1)) : amount_i;
        acc_o     = go_left ? (acc_i << magnitude) : (acc_i >> magnitude);
    end

endmodule

// File: rtl/afu_pos_step.sv
module afu_pos_step #(
    parameter int POS_W  = 6,
    parameter int SIZE_W = 5,
    parameter int STEP   = 32
) (
    input  logic [POS_W-1:0]  pos_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [POS_W-1:0]  dec_pos_o,
    output logic              inc_ok_o,
    output logic [POS_W-1:0]  inc_pos_o
);
    localparam int CMP_W = POS_W + 1;

    always_comb begin
        dec_pos_o = pos_i - POS_W'(size_i) - POS_W'(1);
        inc_ok_o  = ({1'b0, pos_i} <= CMP_W'(STEP));
        inc_pos_o = pos_i + POS_W'(STEP);
    end

endmodule

// File: rtl/acc_field_unit.sv
module acc_field_unit
    import afu_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               op_valid_i,
    input  logic [1:0]         op_code_i,
    input  logic [SIZE_W-1:0]  size_i,
    input  logic [HALF_W-1:0]  operand_i,
    input  logic [HALF_W-1:0]  acc_hi_i,
    input  logic [HALF_W-1:0]  acc_lo_i,
    input  logic [POS_W-1:0]   pos_i,
    output logic [HALF_W-1:0]  acc_hi_o,
    output logic [HALF_W-1:0]  acc_lo_o,
    output logic               acc_we_o,
    output logic [POS_W-1:0]   pos_o,
    output logic               pos_we_o,
    output logic [FIELD_W-1:0] field_o,
    output logic               fail_o
);
    state_t st_d, st_q;

    logic [ACC_W-1:0]   acc_in;
    logic [ACC_W-1:0]   acc_shifted;
    logic               ext_legal;
    logic [FIELD_W-1:0] ext_field;
    logic [POS_W-1:0]   dec_pos;
    logic               inc_ok;
    logic [POS_W-1:0]   inc_pos;
    op_e                op;

    assign acc_in = {acc_hi_i, acc_lo_i};
    assign op     = op_e'(op_code_i);

    afu_field_extract #(
        .ACC_W  (ACC_W),
        .POS_W  (POS_W),
        .SIZE_W (SIZE_W),
        .FIELD_W(FIELD_W)
    ) u_extract (
        .acc_i  (acc_in),
        .pos_i  (pos_i),
        .size_i (size_i),
        .legal_o(ext_legal),
        .field_o(ext_field)
    );

    afu_acc_shift #(
        .ACC_W  (ACC_W),
        .SHAMT_W(SHAMT_W)
    ) u_shift (
        .acc_i   (acc_in),
        .amount_i(operand_i[SHAMT_W-1:0]),
        .acc_o   (acc_shifted)
    );

    afu_pos_step #(
        .POS_W (POS_W),
        .SIZE_W(SIZE_W),
        .STEP  (HALF_W)
    ) u_pos (
        .pos_i    (pos_i),
        .size_i   (size_i),
        .dec_pos_o(dec_pos),
        .inc_ok_o (inc_ok),
        .inc_pos_o(inc_pos)
    );

    always_comb begin
        st_d        = st_q;
        st_d.acc_we = 1'b0;
        st_d.pos_we = 1'b0;
        if (op_valid_i) begin
            unique case (op)
                OP_EXTRACT, OP_EXTRACT_DEC: begin
                    st_d.field = ext_field;
                    st_d.fail  = ~ext_legal;
                    if (op == OP_EXTRACT_DEC && ext_legal) begin
                        st_d.pos    = dec_pos;
                        st_d.pos_we = 1'b1;
                    end
                end
                OP_MOVE: begin
                    st_d.hi     = acc_lo_i;
                    st_d.lo     = operand_i;
                    st_d.acc_we = 1'b1;
                    if (inc_ok) begin
                        st_d.pos    = inc_pos;
                        st_d.pos_we = 1'b1;
                    end
                end
                OP_SHIFT: begin
                    st_d.hi     = acc_shifted[ACC_W-1:HALF_W];
                    st_d.lo     = acc_shifted[HALF_W-1:0];
                    st_d.acc_we = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_hi_o = st_q.hi;
    assign acc_lo_o = st_q.lo;
    assign acc_we_o = st_q.acc_we;
    assign pos_o    = st_q.pos;
    assign pos_we_o = st_q.pos_we;
    assign field_o  = st_q.field;
    assign fail_o   = st_q.fail;

endmodule

// File: rtl/acc_field_unit_chk.sv
module acc_field_unit_chk
    import afu_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic               op_valid_i,
    input logic [1:0]         op_code_i,
    input logic [SIZE_W-1:0]  size_i,
    input logic [HALF_W-1:0]  operand_i,
    input logic [HALF_W-1:0]  acc_hi_i,
    input logic [HALF_W-1:0]  acc_lo_i,
    input logic [POS_W-1:0]   pos_i,
    input logic [HALF_W-1:0]  acc_hi_o,
    input logic [HALF_W-1:0]  acc_lo_o,
    input logic               acc_we_o,
    input logic [POS_W-1:0]   pos_o,
    input logic               pos_we_o,
    input logic [FIELD_W-1:0] field_o,
    input logic               fail_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!acc_we_o && !pos_we_o && !fail_o && field_o == '0 && pos_o == '0));

    // R3
    fail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(op_valid_i) && !$past(op_code_i[1]) && fail_o)
        |-> field_o == '0);

    // R4
    step_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(op_valid_i) && $past(op_code_i) == OP_EXTRACT_DEC && !fail_o)
        |-> (pos_we_o && pos_o == ($past(pos_i) - POS_W'($past(size_i)) - POS_W'(1))));

    // R4
    plain_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(op_valid_i) && $past(op_code_i) == OP_EXTRACT)
        |-> (!pos_we_o && !acc_we_o));

    // R5
    move_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(op_valid_i) && $past(op_code_i) == OP_MOVE)
        |-> (acc_we_o && acc_hi_o == $past(acc_lo_i) && acc_lo_o == $past(operand_i)));

    // R6
    move_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(op_valid_i) && $past(op_code_i) == OP_MOVE)
        |-> (pos_we_o == ($past(pos_i) <= POS_W'(HALF_W))));

    // R8
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(op_valid_i))
        |-> (!acc_we_o && !pos_we_o && $stable(field_o) && $stable(fail_o)
             && $stable(pos_o) && $stable(acc_hi_o) && $stable(acc_lo_o)));

endmodule

bind acc_field_unit acc_field_unit_chk u_chk (.*);

// File: tb/acc_field_unit_tb.sv
module acc_field_unit_tb;
    import afu_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               op_valid = 1'b0;
    logic [1:0]         op_code = '0;
    logic [SIZE_W-1:0]  size = '0;
    logic [HALF_W-1:0]  operand = '0;
    logic [HALF_W-1:0]  acc_hi = '0;
    logic [HALF_W-1:0]  acc_lo = '0;
    logic [POS_W-1:0]   pos = '0;
    logic [HALF_W-1:0]  acc_hi_o, acc_lo_o;
    logic               acc_we_o, pos_we_o, fail_o;
    logic [POS_W-1:0]   pos_o;
    logic [FIELD_W-1:0] field_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [HALF_W-1:0]  e_hi = '0, e_lo = '0;
    logic               e_acc_we = 1'b0, e_pos_we = 1'b0, e_fail = 1'b0;
    logic [POS_W-1:0]   e_pos = '0;
    logic [FIELD_W-1:0] e_field = '0;

    always #5 clk = ~clk;

    acc_field_unit u_dut (
        .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
        .size_i(size), .operand_i(operand), .acc_hi_i(acc_hi), .acc_lo_i(acc_lo),
        .pos_i(pos), .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .acc_we_o(acc_we_o),
        .pos_o(pos_o), .pos_we_o(pos_we_o), .field_o(field_o), .fail_o(fail_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string t_fld, input string t_acc, input string t_pos);
        chk(t_fld, "field", 64'(field_o), 64'(e_field));
        chk(t_fld, "fail", 64'(fail_o), 64'(e_fail));
        chk(t_acc, "acc_we", 64'(acc_we_o), 64'(e_acc_we));
        chk(t_acc, "acc", {acc_hi_o, acc_lo_o}, {e_hi, e_lo});
        chk(t_pos, "pos_we", 64'(pos_we_o), 64'(e_pos_we));
        chk(t_pos, "pos", 64'(pos_o), 64'(e_pos));
    endtask

    // Drive at a falling edge, compute the expectation, sample at the next falling edge.
    task automatic apply(input logic v, input logic [1:0] oc, input logic [4:0] sz,
                         input logic [31:0] opnd, input logic [31:0] hi,
                         input logic [31:0] lo, input logic [5:0] p);
        logic [63:0] acc;
        logic signed [5:0] samt;
        int s;
        string t_fld, t_acc, t_pos;
        op_valid = v; op_code = oc; size = sz; operand = opnd;
        acc_hi = hi; acc_lo = lo; pos = p;
        acc = {hi, lo};
        e_acc_we = 1'b0; e_pos_we = 1'b0;
        t_fld = "R8"; t_acc = "R8"; t_pos = "R8";
        if (v) begin
            if (oc == 2'b00 || oc == 2'b01) begin
                t_acc = "R4";
                t_pos = "R4";
                if (int'(p) - (int'(sz) + 1) >= -1) begin
                    t_fld = "R2";
                    e_fail = 1'b0;
                    e_field = 32'((acc >> (p - 6'(sz))) & ((64'd1 << (int'(sz) + 1)) - 64'd1));
                    if (oc == 2'b01) begin
                        e_pos_we = 1'b1;
                        e_pos = 6'(int'(p) - int'(sz) - 1);
                    end
                end else begin
                    t_fld = "R3";
                    e_fail = 1'b1;
                    e_field = '0;
                end
            end else if (oc == 2'b10) begin
                t_acc = "R5"; t_pos = "R6";
                e_hi = lo; e_lo = opnd; e_acc_we = 1'b1;
                if (p <= 6'd32) begin
                    e_pos_we = 1'b1;
                    e_pos = 6'(int'(p) + 32);
                end
            end else begin
                t_acc = "R7";
                samt = opnd[5:0];
                s = int'(samt);
                if (s > 0)      acc = acc >> s;
                else if (s < 0) acc = acc << (-s);
                e_hi = acc[63:32]; e_lo = acc[31:0]; e_acc_we = 1'b1;
            end
        end
        @(negedge clk);
        compare_all(t_fld, t_acc, t_pos);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R1: reset state
        compare_all("R1", "R1", "R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1", "R1", "R1");

        // R2 directed: top field and single bits
        apply(1, 2'b00, 5'd31, 0, 32'hA5C3_0F81, 32'h1234_5678, 6'd63);
        apply(1, 2'b00, 5'd0,  0, 32'h0, 32'h0000_0001, 6'd0);
        apply(1, 2'b00, 5'd7,  0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 6'd39);
        // R3 directed: one short
        apply(1, 2'b00, 5'd9,  0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd8);
        // R8: move leaves fail flag
        apply(1, 2'b10, 5'd0, 32'h0BAD_CAFE, 32'h1, 32'h2, 6'd40);
        // R4 directed: pointer equal to size wraps to 63
        apply(1, 2'b01, 5'd5,  0, 32'h0, 32'h0000_003F, 6'd5);
        apply(1, 2'b01, 5'd6,  0, 32'h0, 32'h0, 6'd5);
        apply(1, 2'b01, 5'd15, 0, 32'h8000_0000, 32'h0, 6'd63);
        // R6 directed: boundary 32 and 33
        apply(1, 2'b10, 5'd0, 32'h1111_1111, 32'h2, 32'h3, 6'd32);
        apply(1, 2'b10, 5'd0, 32'h2222_2222, 32'h4, 32'h5, 6'd33);
        apply(1, 2'b10, 5'd0, 32'h3333_3333, 32'h6, 32'h7, 6'd0);
        // R7 directed: -32, +31, 0, upper operand bits ignored
        apply(1, 2'b11, 5'd0, 32'h0000_0020, 32'h0123_4567, 32'h89AB_CDEF, 6'd1);
        apply(1, 2'b11, 5'd0, 32'h0000_001F, 32'hF000_0000, 32'h0, 6'd1);
        apply(1, 2'b11, 5'd0, 32'hFFFF_FFC0, 32'h1357_9BDF, 32'h2468_ACE0, 6'd1);
        apply(1, 2'b11, 5'd0, 32'h0000_003F, 32'h8000_0000, 32'h0000_0001, 6'd1);
        // R8 directed: idle with garbage
        apply(0, 2'b01, 5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd20);

        for (int i = 0; i < 3000; i++) begin
            logic v;
            logic [5:0] p;
            v = ($urandom % 8) != 0;
            p = 6'($urandom);
            if (($urandom % 4) == 0) p = 6'($urandom % 8);
            apply(v, 2'($urandom), 5'($urandom), $urandom, $urandom, $urandom, p);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule